// File: doc/BRIEF.md
# I2C Slave Bus Front End

This block is the protocol engine of an I2C target. It runs on a fast system clock and oversamples the bus clock and data lines through a short synchronizer. From the synchronized lines it detects start, repeated start and stop conditions, and from these it tracks the bus cycle. It answers to one fixed 7-bit address, to one 10-bit address and to the general call address, and it acknowledges every byte it accepts. The data output is open-drain and is modelled as a single pull-low enable. The enable changes only while the bus clock is low.

On the register side, the first data byte of a write sets a register pointer. Every later byte comes out as a write strobe carrying the pointer and the data, and the pointer then advances. Reads take the byte at the current pointer from a combinational data input, shift it out MSB first and advance the pointer. General call bytes are strobed with a flag and do not move the pointer.

The controller has eight states. `ST_IDLE` waits for a start. `ST_ADDR` and `ST_ADDR2` receive the first and second address bytes. `ST_RX` receives data bytes. `ST_ACK` holds the acknowledge. `ST_TX` shifts out a read byte. `ST_TXACK` samples the master's acknowledge. `ST_SKIP` ignores the bus until the next start or stop.

The transitions are as follows:
- Start moves any state to `ST_ADDR`.
- Stop moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ACK` on an accepted address and to `ST_SKIP` otherwise.
- `ST_ADDR2` goes to `ST_ACK` on a low-byte match and to `ST_SKIP` otherwise.
- `ST_RX` goes to `ST_ACK` after eight bits.
- `ST_ACK` goes to `ST_ADDR2`, `ST_RX` or `ST_TX`, as decided by the byte it acknowledged.
- `ST_TX` goes to `ST_TXACK` after eight bits.
- `ST_TXACK` goes back to `ST_TX` on a master ACK and to `ST_SKIP` on a NoAck.

Top module: `i2c_target_engine`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Before the first start, clocked bytes are never acknowledged.
- R2: A first byte of 0xB0 (7-bit address 0x58 with R/W bit 0 = write) or 0xB1 (read) is acknowledged by holding SDA low through the ninth clock.
- R3: Any other first byte that is not a valid general call or 10-bit header is not acknowledged. All further bytes up to the next start are ignored: no ACK and no strobe.
- R4: In a write, the first data byte loads the pointer and is acknowledged without a strobe. Each later byte gives one `wr_stb_o` pulse with `wr_addr_o` = pointer and `wr_data_o` = byte, and is acknowledged. The pointer then increments.
- R5: In a read, the byte at the current pointer is shifted out MSB first, and the pointer increments per byte. A master ACK fetches the next byte.
- R6: A read byte that gets a master NoAck, followed by a stop, returns the engine to idle with SDA released. A following transaction is served normally.
- R7: A first byte of 0x00 (general call, write) is acknowledged. Its data bytes are acknowledged and strobed with `wr_gc_o` = 1 and `wr_addr_o` = current pointer, and the pointer does not change.
- R8: A 10-bit write is a header 0b11110, then address bits 9:8 (2'b10 for address 0x2A5), then write bit 0 (byte 0xF4), followed by the low byte 0xA5. Both are acknowledged. A mismatch in either byte is not acknowledged.
- R9: A header 0xF5 (read) is accepted only after a repeated start that follows a completed 10-bit address match. After a stop, it is not acknowledged.
- R10: `sda_pull_o` changes only while SCL is low.
- R11: After a stop ends a write, bytes clocked without a new start are ignored and change no register.
- R12: After reset `sda_pull_o`, `wr_stb_o` and `rd_stb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, much faster than SCL |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_i | input | 1 | bus clock line (raw) |
| sda_i | input | 1 | bus data line as seen on the wire (raw) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_stb_o | output | 1 | one-cycle write strobe |
| wr_gc_o | output | 1 | the strobed byte belongs to a general call |
| wr_addr_o | output | PTR_W | register pointer of the strobed byte |
| wr_data_o | output | 8 | strobed write data |
| rd_stb_o | output | 1 | one-cycle pulse when a read byte is taken |
| rd_addr_o | output | PTR_W | current pointer for the read side |
| rd_data_i | input | 8 | register data at `rd_addr_o`, combinational |

## Verification
The bench first clocks bytes with no start and after a stop. An engine that does not wait for a start would acknowledge them or strobe stray writes. It sends wrong 7-bit addresses, wrong 10-bit headers and wrong 10-bit low bytes. An engine with a loose address compare would pull SDA or emit writes there. It reads with a master ACK and then a NoAck and stop, and then runs a fresh read. An engine that kept driving after the NoAck would block the stop or corrupt the next pointer. It checks that a 10-bit read header is accepted only across a repeated start and that a general call leaves the pointer where it was. Errors in either of these would show up as a missing acknowledge or as data read from the wrong address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        AK_ADDR2,
        AK_RX,
        AK_TX
    } ack_next_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_o      = scl_sh[STAGES-1];
    assign sda_o      = sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_p;
    assign scl_fall_o = ~scl_o & scl_p;
    assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
    assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/i2c_addr_decode.sv
module i2c_addr_decode #(
    parameter logic [6:0] ADDR7  = 7'h58,
    parameter logic [9:0] ADDR10 = 10'h2A5
) (
    input  logic [7:0] octet_i,
    output logic       hit7_o,
    output logic       gc_o,
    output logic       hi_wr_o,
    output logic       hi_rd_o,
    output logic       lo_o
);

    localparam logic [4:0] HDR10 = 5'b11110;

    logic hdr_ok;

    assign hdr_ok  = (octet_i[7:3] == HDR10) && (octet_i[2:1] == ADDR10[9:8]);
    assign hit7_o  = (octet_i[7:1] == ADDR7);
    assign gc_o    = (octet_i == 8'h00);
    assign hi_wr_o = hdr_ok && !octet_i[0];
    assign hi_rd_o = hdr_ok && octet_i[0];
    assign lo_o    = (octet_i == ADDR10[7:0]);

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h58,
    parameter logic [9:0] ADDR10      = 10'h2A5,
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic             wr_stb_o,
    output logic             wr_gc_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic             rd_stb_o,
    output logic [PTR_W-1:0] rd_addr_o,
    input  logic [7:0]       rd_data_i
);

    localparam int                BITS     = 8;
    localparam int                CNT_W    = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BITS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    tgt_state_e       state_q, state_d;
    ack_next_e        nxt_q;
    logic [7:0]       sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] ptr_q;
    logic             pull_q, ptr_phase_q, gc_q, ten_sel_q, mack_q;

    logic hit7, hit_gc, hi_wr, hi_rd, hit_lo;

    i2c_addr_decode #(.ADDR7(ADDR7), .ADDR10(ADDR10)) u_dec (
        .octet_i (sh_q),
        .hit7_o  (hit7),
        .gc_o    (hit_gc),
        .hi_wr_o (hi_wr),
        .hi_rd_o (hi_rd),
        .lo_o    (hit_lo)
    );

    logic byte_done, addr_ok, tx_load;

    assign byte_done = scl_fall && (cnt_q == LAST_BIT);
    assign addr_ok   = hit7 || hit_gc || hi_wr || (hi_rd && ten_sel_q);
    assign tx_load   = scl_fall && !start_det && !stop_det &&
                       (((state_q == ST_ACK) && (nxt_q == AK_TX)) ||
                        ((state_q == ST_TXACK) && mack_q));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  if (byte_done) state_d = addr_ok ? ST_ACK : ST_SKIP;
                ST_ADDR2: if (byte_done) state_d = hit_lo ? ST_ACK : ST_SKIP;
                ST_RX:    if (byte_done) state_d = ST_ACK;
                ST_ACK: begin
                    if (scl_fall) begin
                        if (nxt_q == AK_ADDR2)   state_d = ST_ADDR2;
                        else if (nxt_q == AK_TX) state_d = ST_TX;
                        else                     state_d = ST_RX;
                    end
                end
                ST_TX:    if (byte_done) state_d = ST_TXACK;
                ST_TXACK: if (scl_fall) state_d = mack_q ? ST_TX : ST_SKIP;
                ST_SKIP:  state_d = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q       <= AK_RX;
            sh_q        <= '0;
            cnt_q       <= '0;
            ptr_q       <= '0;
            pull_q      <= 1'b0;
            ptr_phase_q <= 1'b0;
            gc_q        <= 1'b0;
            ten_sel_q   <= 1'b0;
            mack_q      <= 1'b0;
            wr_stb_o    <= 1'b0;
            wr_gc_o     <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            rd_stb_o    <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            rd_stb_o <= 1'b0;
            if (start_det) begin
                cnt_q  <= '0;
                pull_q <= 1'b0;
            end else if (stop_det) begin
                cnt_q     <= '0;
                pull_q    <= 1'b0;
                ten_sel_q <= 1'b0;
                gc_q      <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_ADDR2, ST_RX: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_s};
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                        if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                pull_q      <= addr_ok;
                                gc_q        <= hit_gc;
                                ptr_phase_q <= !hit_gc;
                                ten_sel_q   <= hi_rd && ten_sel_q;
                                nxt_q       <= hi_wr ? AK_ADDR2 : (sh_q[0] ? AK_TX : AK_RX);
                            end else if (state_q == ST_ADDR2) begin
                                pull_q      <= hit_lo;
                                ten_sel_q   <= hit_lo;
                                ptr_phase_q <= 1'b1;
                                nxt_q       <= AK_RX;
                            end else begin
                                pull_q <= 1'b1;
                                nxt_q  <= AK_RX;
                                if (gc_q) begin
                                    wr_stb_o  <= 1'b1;
                                    wr_gc_o   <= 1'b1;
                                    wr_addr_o <= ptr_q;
                                    wr_data_o <= sh_q;
                                end else if (ptr_phase_q) begin
                                    ptr_q       <= PTR_W'(sh_q);
                                    ptr_phase_q <= 1'b0;
                                end else begin
                                    wr_stb_o  <= 1'b1;
                                    wr_gc_o   <= 1'b0;
                                    wr_addr_o <= ptr_q;
                                    wr_data_o <= sh_q;
                                    ptr_q     <= ptr_q + PTR_W'(1);
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q  <= '0;
                            pull_q <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) cnt_q <= cnt_q + CNT_W'(1);
                        if (scl_fall) begin
                            if (cnt_q == LAST_BIT) begin
                                cnt_q  <= '0;
                                pull_q <= 1'b0;
                            end else begin
                                sh_q   <= {sh_q[6:0], 1'b0};
                                pull_q <= ~sh_q[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall) cnt_q <= '0;
                    end
                    ST_IDLE, ST_SKIP: begin
                    end
                endcase
                if (tx_load) begin
                    sh_q     <= rd_data_i;
                    pull_q   <= ~rd_data_i[7];
                    rd_stb_o <= 1'b1;
                    ptr_q    <= ptr_q + PTR_W'(1);
                end
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign rd_addr_o  = ptr_q;

    // R10: drive changes only when the synchronized clock was low
    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_q) |-> !$past(scl_s));

    // R2/R5: the line is pulled only while acknowledging or transmitting
    assert_pull_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pull_q |-> (state_q == ST_ACK || state_q == ST_TX));

    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state_q == ST_ADDR);

    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state_q == ST_IDLE);

    assert_wr_from_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(state_q) == ST_RX);

    assert_gc_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o && wr_gc_o) |-> $stable(ptr_q));

    assert_rd_in_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> state_q == ST_TX);

endmodule

// File: tb/sim_i2c_target_engine.sv
module sim_i2c_target_engine;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull, wr_stb, wr_gc, rd_stb;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    wire        sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2c_target_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .wr_stb_o   (wr_stb),
        .wr_gc_o    (wr_gc),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_stb_o   (rd_stb),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data)
    );

    logic [7:0]  regs    [256];
    logic [7:0]  exp_mem [256];
    logic [16:0] sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          viol = 0;
    bit          done = 1'b0;
    logic        prev_pull = 1'b0;

    assign rd_data = regs[rd_addr];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic clk_bit(input bit b, output bit s);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        s = sda_bus;  wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(!mack, s);
    endtask

    task automatic exp_wr(input bit gc, input logic [7:0] a, input logic [7:0] d);
        sb_q.push_back({gc, a, d});
        if (!gc) exp_mem[a] = d;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3 R11 unexpected write", {wr_gc, wr_addr, wr_data}, 0);
            end else begin
                logic [16:0] item;
                item = sb_q.pop_front();
                chk({wr_gc, wr_addr, wr_data} == item, item[16] ? "R7 write item" : "R4 write item",
                    {wr_gc, wr_addr, wr_data}, item);
            end
            if (!wr_gc) regs[wr_addr] = wr_data;
        end
        if (rst_n && sda_pull !== prev_pull && scl_m) viol++;
        prev_pull = sda_pull;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        bit         ack;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) begin
            regs[i]    = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0 && wr_stb == 1'b0 && rd_stb == 1'b0, "R12 reset outputs",
            {sda_pull, wr_stb, rd_stb}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        scl_m = 1'b0; wait_q();

        // R1: no start yet
        send_byte(8'hB0, ack); chk(!ack, "R1 no ack before start", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R1 no ack before start gc", ack, 0);
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();

        // R2/R4: 7-bit write
        bus_start();
        send_byte(8'hB0, ack); chk(ack, "R2 write address ack", ack, 1);
        send_byte(8'h10, ack); chk(ack, "R4 pointer byte ack", ack, 1);
        exp_wr(0, 8'h10, 8'hA5);
        send_byte(8'hA5, ack); chk(ack, "R4 data ack", ack, 1);
        exp_wr(0, 8'h11, 8'h3C);
        send_byte(8'h3C, ack); chk(ack, "R4 data ack", ack, 1);
        bus_stop();
        wait_q();
        chk(sb_q.size() == 0, "R4 writes delivered", sb_q.size(), 0);

        // R5/R6: read via repeated start
        bus_start();
        send_byte(8'hB0, ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte(8'hB1, ack); chk(ack, "R2 read address ack", ack, 1);
        recv_byte(1'b1, d); chk(d == exp_mem[8'h10], "R5 read byte 0", d, exp_mem[8'h10]);
        recv_byte(1'b0, d); chk(d == exp_mem[8'h11], "R5 read byte 1", d, exp_mem[8'h11]);
        bus_stop();
        wait_q();
        chk(sda_pull == 1'b0, "R6 released after nack stop", sda_pull, 0);

        // R6: next transaction after nack
        bus_start();
        send_byte(8'hB1, ack); chk(ack, "R6 next read acked", ack, 1);
        recv_byte(1'b0, d); chk(d == exp_mem[8'h12], "R6 next read data", d, exp_mem[8'h12]);
        bus_stop();

        // R3: wrong address
        bus_start();
        send_byte(8'hB4, ack); chk(!ack, "R3 wrong address nack", ack, 0);
        send_byte(8'h20, ack); chk(!ack, "R3 ignored byte", ack, 0);
        send_byte(8'h99, ack); chk(!ack, "R3 ignored byte", ack, 0);
        bus_stop();

        // R7: general call, pointer stays at 0x13
        bus_start();
        send_byte(8'h00, ack); chk(ack, "R7 general call ack", ack, 1);
        exp_wr(1, 8'h13, 8'h06);
        send_byte(8'h06, ack); chk(ack, "R7 general call data ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'hB1, ack);
        recv_byte(1'b0, d); chk(d == exp_mem[8'h13], "R7 pointer unchanged", d, exp_mem[8'h13]);
        bus_stop();

        // R8: 10-bit write
        bus_start();
        send_byte(8'hF4, ack); chk(ack, "R8 header ack", ack, 1);
        send_byte(8'hA5, ack); chk(ack, "R8 low byte ack", ack, 1);
        send_byte(8'h20, ack);
        exp_wr(0, 8'h20, 8'h77);
        send_byte(8'h77, ack);
        exp_wr(0, 8'h21, 8'h88);
        send_byte(8'h88, ack); chk(ack, "R8 data ack", ack, 1);
        bus_stop();

        // R9: 10-bit read via repeated start
        bus_start();
        send_byte(8'hF4, ack);
        send_byte(8'hA5, ack);
        send_byte(8'h20, ack);
        bus_start();
        send_byte(8'hF5, ack); chk(ack, "R9 read header ack", ack, 1);
        recv_byte(1'b1, d); chk(d == 8'h77, "R9 read data 0", d, 8'h77);
        recv_byte(1'b0, d); chk(d == 8'h88, "R9 read data 1", d, 8'h88);
        bus_stop();

        // R9: read header after stop is refused
        bus_start();
        send_byte(8'hF5, ack); chk(!ack, "R9 unselected read header", ack, 0);
        bus_stop();

        // R8: mismatches
        bus_start();
        send_byte(8'hF4, ack);
        send_byte(8'hA6, ack); chk(!ack, "R8 wrong low byte", ack, 0);
        send_byte(8'h30, ack); chk(!ack, "R8 ignored after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hF2, ack); chk(!ack, "R8 wrong header bits", ack, 0);
        bus_stop();

        // R11: stop ends the write
        bus_start();
        send_byte(8'hB0, ack);
        send_byte(8'h40, ack);
        exp_wr(0, 8'h40, 8'h11);
        send_byte(8'h11, ack);
        bus_stop();
        scl_m = 1'b0; wait_q();
        send_byte(8'h22, ack); chk(!ack, "R11 byte after stop ignored", ack, 0);
        send_byte(8'h33, ack); chk(!ack, "R11 byte after stop ignored", ack, 0);
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        bus_start();
        send_byte(8'hB0, ack);
        send_byte(8'h40, ack);
        bus_start();
        send_byte(8'hB1, ack);
        recv_byte(1'b1, d); chk(d == 8'h11, "R11 last write kept", d, 8'h11);
        recv_byte(1'b0, d); chk(d == exp_mem[8'h41], "R11 next register untouched", d, exp_mem[8'h41]);
        bus_stop();

        wait_q();
        chk(viol == 0, "R10 drive change while SCL high", viol, 0);
        chk(sb_q.size() == 0, "R4 R7 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule